// File: doc/BRIEF.md
# Time-Multiplexed Four-Product Generator

This block forms four constant products of a single signed input sample within one main-clock period. It runs on a clock four times faster than the main clock. A strobe marks the first fast cycle of each main period. One selectable shift-add multiplier is reused in every quarter of the period. Each quarter the multiplier takes a different coefficient, chosen by a 2-bit quarter index and a 3-bit transform selector. The finished products collect in a small register bank. When the last quarter completes, all four are released together.

Input is accepted through a valid/ready pair. Ready is raised only in the strobe cycle, and a sample offered in any other cycle is simply not taken. The output side has no back-pressure. `out_valid` is a single-cycle pulse, and the consumer must take the group in that cycle. The product lines then hold the group until the next one completes.

Top module: `tdm_quad_mult`

## Requirements
- R1: A sample and transform selector are taken only at a fast edge where `strobe` and `in_valid` are both high, and `in_ready` is high exactly in strobe cycles. Values on `sample`, `tsel` and `in_valid` in non-strobe cycles do not alter the group in progress.
- R2: After acceptance the quarter index steps 0,1,2,3 on successive fast edges. Quarter q produces sample × C[tsel][q], and that product lands in `out_prod[q]`.
- R3: `out_valid` is high for one fast cycle, starting after the fourth fast edge following the accepting edge. In that cycle all four products of the group are present.
- R4: `out_prod` changes only in a cycle where `out_valid` is high. It never shows a mix of two groups.
- R5: The coefficients C[t][0..3] are: t=0 → 64,83,64,36; t=1 → 29,74,84,55; t=2 → 84,74,55,29; t=3 → 194,336,269,117; t=4 → 219,117,194,72.
- R6: Selector values 5, 6 and 7 use coefficient 0, so every product of such a group is 0.
- R7: A strobe that arrives while a group has not yet reached quarter 3 abandons that group. No `out_valid` is raised for it. A strobe in the quarter-3 cycle does not disturb the finishing group.
- R8: A strobe with `in_valid` low starts no group.
- R9: `sample` is two's complement. Products are signed, `SAMPLE_W+9` bits wide, and exact over the full input range, including -512 × 511.
- R10: While `rst_n` is low, `out_valid` and all products are 0 and any group in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the main rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | High in the first fast cycle of each main period |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken this cycle (strobe cycle) |
| sample | input | SAMPLE_W (10) | Signed input sample |
| tsel | input | 3 | Transform selector |
| out_valid | output | 1 | One-cycle pulse: four products ready |
| out_prod | output | 4 × (SAMPLE_W+9) | Products, index = coefficient position |

## Verification
The bench puts noise on `sample`, `tsel` and `in_valid` between strobes. A design that did not hold its captured operands would mix in that noise and produce wrong products. Early strobes test group abandonment: a design that failed to drop the group would pulse `out_valid` with no matching expectation. Back-to-back periods, where the next strobe falls on quarter 3, test the opposite fault: a design that wrongly dropped the finishing group would leave an expectation unmet. The bench also drives the extreme negative sample, selectors 5 to 7, and a reset in mid-group. These expose sign-extension errors, a missing zero coefficient, and a group that survives reset.

// File: rtl/tqm_pkg.sv
package tqm_pkg;
  localparam int NQ  = 4;            // quarters per main period
  localparam int QW  = $clog2(NQ);
  localparam int NT  = 5;            // defined transform sets
  localparam int TW  = 3;            // selector width
  localparam int CW  = 9;            // coefficient width (unsigned)

  typedef logic [QW-1:0] quarter_t;
  typedef logic [TW-1:0] tsel_t;
  typedef logic [CW-1:0] coef_t;

  function automatic coef_t coef_of(input tsel_t t, input quarter_t q);
    coef_t c;
    case ({t, q})
      {3'd0, 2'd0}: c = 9'd64;
      {3'd0, 2'd1}: c = 9'd83;
      {3'd0, 2'd2}: c = 9'd64;
      {3'd0, 2'd3}: c = 9'd36;
      {3'd1, 2'd0}: c = 9'd29;
      {3'd1, 2'd1}: c = 9'd74;
      {3'd1, 2'd2}: c = 9'd84;
      {3'd1, 2'd3}: c = 9'd55;
      {3'd2, 2'd0}: c = 9'd84;
      {3'd2, 2'd1}: c = 9'd74;
      {3'd2, 2'd2}: c = 9'd55;
      {3'd2, 2'd3}: c = 9'd29;
      {3'd3, 2'd0}: c = 9'd194;
      {3'd3, 2'd1}: c = 9'd336;
      {3'd3, 2'd2}: c = 9'd269;
      {3'd3, 2'd3}: c = 9'd117;
      {3'd4, 2'd0}: c = 9'd219;
      {3'd4, 2'd1}: c = 9'd117;
      {3'd4, 2'd2}: c = 9'd194;
      {3'd4, 2'd3}: c = 9'd72;
      default:      c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tqm_phase_ctl.sv
module tqm_phase_ctl
  import tqm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     strobe,
  input  logic     start,
  output quarter_t phase,
  output logic     run,
  output logic     done
);
  localparam quarter_t LAST = quarter_t'(NQ - 1);

  assign done = run && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      run   <= 1'b0;
    end else if (strobe) begin
      phase <= '0;
      run   <= start;
    end else if (run) begin
      phase <= phase + quarter_t'(1);
      if (phase == LAST) run <= 1'b0;
    end
  end

  // R2: quarters advance one per fast edge while a group runs
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !strobe && phase != LAST) |=> (run && phase == $past(phase) + quarter_t'(1)));

  // R7: an early strobe restarts at quarter 0
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (phase == '0));
endmodule

// File: rtl/tqm_coef_sel.sv
module tqm_coef_sel
  import tqm_pkg::*;
(
  input  tsel_t    tsel,
  input  quarter_t quarter,
  output coef_t    coef
);
  assign coef = coef_of(tsel, quarter);
endmodule

// File: rtl/tqm_shift_add.sv
module tqm_shift_add
  import tqm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  localparam int PW = SAMPLE_W + CW
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample,
  input  coef_t               coef,
  output logic [PW-1:0]       prod
);
  logic [PW-1:0] sext;
  logic [PW-1:0] part [CW];

  assign sext = {{(PW-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};

  for (genvar k = 0; k < CW; k++) begin : g_term
    assign part[k] = coef[k] ? (sext << k) : '0;
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < CW; k++) prod = prod + part[k];
  end

  // R6: a zero coefficient must yield a zero product
  a_r6_zero_coef: assert property (@(posedge clk) disable iff (!rst_n)
    (coef == '0) |-> (prod == '0));
endmodule

// File: rtl/tqm_bank.sv
module tqm_bank
  import tqm_pkg::*;
#(
  parameter int PW = 19
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 done,
  input  quarter_t             phase,
  input  logic [PW-1:0]        prod,
  output logic                 out_valid,
  output logic [NQ-1:0][PW-1:0] out_prod
);
  logic [PW-1:0] hold [NQ-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ-1; q++) hold[q] <= '0;
      out_prod  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= done;
      for (int q = 0; q < NQ-1; q++)
        if (run && phase == quarter_t'(q)) hold[q] <= prod;
      if (done) begin
        for (int q = 0; q < NQ-1; q++) out_prod[q] <= hold[q];
        out_prod[NQ-1] <= prod;
      end
    end
  end

  // R3: the ready pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4: products move only as a group with the pulse
  a_r4_group_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_prod));
endmodule

// File: rtl/tdm_quad_mult.sv
module tdm_quad_mult
  import tqm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  localparam int PW = SAMPLE_W + CW
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SAMPLE_W-1:0]   sample,
  input  logic [2:0]            tsel,
  output logic                  out_valid,
  output logic [3:0][PW-1:0]    out_prod
);
  logic [SAMPLE_W-1:0] smp_q;
  tsel_t               tid_q;
  quarter_t            phase;
  logic                run, done, take;
  coef_t               coef;
  logic [PW-1:0]       prod;

  assign in_ready = strobe;
  assign take     = strobe && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      tid_q <= '0;
    end else if (take) begin
      smp_q <= sample;
      tid_q <= tsel;
    end
  end

  tqm_phase_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .start(take),
    .phase(phase), .run(run), .done(done)
  );

  tqm_coef_sel u_coef (.tsel(tid_q), .quarter(phase), .coef(coef));

  tqm_shift_add #(.SAMPLE_W(SAMPLE_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .sample(smp_q), .coef(coef), .prod(prod)
  );

  tqm_bank #(.PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n), .run(run), .done(done), .phase(phase),
    .prod(prod), .out_valid(out_valid), .out_prod(out_prod)
  );

  // R1: operands stay fixed while the quarters run
  a_r1_operand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !strobe) |=> ($stable(smp_q) && $stable(tid_q)));

  // R8: a strobe without a sample leaves the engine idle
  a_r8_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !in_valid) |=> !run);
endmodule

// File: tb/tdm_quad_mult_test.sv
module tdm_quad_mult_test;
  localparam int SW = 10;
  localparam int PW = SW + 9;

  typedef struct packed {
    int unsigned          due;
    logic [3:0][PW-1:0]   p;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, in_valid = 1'b0;
  logic [SW-1:0] sample = '0;
  logic [2:0] tsel = '0;
  logic in_ready, out_valid;
  logic [3:0][PW-1:0] out_prod;

  int checks = 0, fails = 0;
  int unsigned cyc = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [3:0][PW-1:0] last;

  always #2.5 clk = ~clk;

  tdm_quad_mult #(.SAMPLE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .in_valid(in_valid),
    .in_ready(in_ready), .sample(sample), .tsel(tsel),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic int ref_coef(int t, int q);
    int tab [5][4] = '{'{64,83,64,36}, '{29,74,84,55}, '{84,74,55,29},
                       '{194,336,269,117}, '{219,117,194,72}};
    if (t > 4) return 0;  // R6
    return tab[t][q];     // R5
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one strobe, then gap-1 cycles of noise before the next strobe
  task automatic run_group(bit v, logic signed [SW-1:0] s, int t, int gap);
    exp_t e;
    @(negedge clk);
    strobe = 1'b1; in_valid = v; sample = s; tsel = 3'(t);
    check(in_ready == 1'b1, "R1 ready on strobe", in_ready, 1);
    if (v && gap >= 4) begin
      e.due = cyc + 5;
      for (int q = 0; q < 4; q++) e.p[q] = PW'(int'(s) * ref_coef(t, q));
      sb.push_back(e);
    end
    for (int i = 1; i < gap; i++) begin
      @(negedge clk);
      strobe = 1'b0;
      in_valid = 1'($urandom);
      sample = SW'($urandom);
      tsel = 3'($urandom);
      if (i == 1) check(in_ready == 1'b0, "R1 ready off strobe", in_ready, 0);
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    last = '0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (!rst_n) begin
        last = out_prod;
      end else if (out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R7 unexpected group", 1, 0);
        end else begin
          e = sb.pop_front();
          check(cyc == e.due, "R3 latency", cyc, e.due);
          for (int q = 0; q < 4; q++)
            check(out_prod[q] == e.p[q], "R2/R5/R9 product",
                  $signed(out_prod[q]), $signed(e.p[q]));
        end
        last = out_prod;
      end else if (out_prod != last) begin
        check(0, "R4 change without valid", 1, 0);
        last = out_prod;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 reset valid", out_valid, 0);
    check(out_prod == '0, "R10 reset products", 1, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R5 each transform set, R1 noise between strobes
    for (int t = 0; t < 5; t++) run_group(1, 10'sd3 + 10'(t), t, 4);
    run_group(1, -10'sd7, 3, 6);
    // R9 extremes
    run_group(1, -10'sd512, 3, 4);
    run_group(1, 10'sd511, 3, 4);
    run_group(1, -10'sd512, 4, 5);
    // R6 undefined selectors
    for (int t = 5; t < 8; t++) run_group(1, 10'sd300, t, 4);
    // R8 strobe without sample
    run_group(0, 10'sd99, 0, 4);
    run_group(1, 10'sd21, 1, 4);
    // R7 early strobes abandon groups
    run_group(1, 10'sd100, 0, 2);
    run_group(1, 10'sd55, 2, 3);
    run_group(1, 10'sd77, 1, 4);
    run_group(0, 10'sd0, 0, 8);
    // R10 reset mid-group
    run_group(1, 10'sd123, 4, 2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", out_valid, 0);
    check(out_prod == '0, "R10 products in reset", 1, 0);
    strobe = 1'b0; in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(out_prod == '0, "R10 group discarded", 1, 0);
    run_group(1, -10'sd1, 2, 4);
    run_group(0, 10'sd0, 0, 10);
    check(sb.size() == 0, "R3 missing group", sb.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule